// File: doc/BRIEF.md
# PCIe Root-Port Power-Up Reset Sequencer

This block walks a PCIe root-port controller and its slot through power-up. It sequences the slot reset line, the slot power enable, the controller's internal reset, the auxiliary clock gate, a PHY/link-state-machine hold, the controller power-up reset and the device-type setting. A separate PHY configuration engine does the PHY register writes. The sequencer asks that engine to run while the PHY is held in reset and waits for its completion handshake. When the engine reports completion, the sequencer turns the auxiliary clock off, drops the PHY hold and turns the clock back on. Last, it selects root-complex mode and raises `done_o`.

A pulse on `start_i` in the idle state starts the sequence. The sequencer switches slot power on and keeps both active-low resets asserted for `PERST_CYCLES` reference clock cycles. The default is 100 ms at 100 MHz, and simulation uses a short count. Every later timed step lasts `STEP_CYCLES` cycles. At any point in a run, `shutdown_i` takes the outputs back to the reset state. The slot line drops first and the controller reset follows, so that a later boot starts clean. All outputs are registered and change on the clock edge where the internal state changes.

Top module: `pcie_pwrup_seq`

## Requirements
- R1: During and after reset every output is low, `dev_type_o` is 0 and the block stays idle until `start_i` is sampled high.
- R2: A `start_i` sampled high in idle raises `slot_pwr_en_o` at that edge. `ctrl_rst_no` and `slot_rst_no` stay low for exactly `PERST_CYCLES` cycles after that.
- R3: `ctrl_rst_no` rises first. `slot_rst_no` rises `STEP_CYCLES` cycles later.
- R4: In order and `STEP_CYCLES` cycles apart, after the slot release: `aux_clk_en_o` rises, then `phy_hold_o` rises, then `pwrup_rst_no` rises.
- R5: `phy_prog_req_o` rises `STEP_CYCLES` cycles after `pwrup_rst_no`. It stays high, with `phy_hold_o` high, until `phy_prog_done_i` is sampled high. It falls at that same edge.
- R6: At the edge where the request falls, `aux_clk_en_o` falls. `phy_hold_o` falls `STEP_CYCLES` cycles later, and `aux_clk_en_o` rises again `STEP_CYCLES` cycles after that.
- R7: `STEP_CYCLES` cycles after the clock returns, `dev_type_o` becomes 4 (root complex) and `done_o` rises. Both hold, and `start_i` is ignored, until shutdown or reset.
- R8: A `shutdown_i` sampled high in any active state drops `slot_rst_no`, `aux_clk_en_o`, `phy_hold_o`, `pwrup_rst_no`, `phy_prog_req_o` and `done_o`, and sets `dev_type_o` to 0, at that edge. `ctrl_rst_no` keeps its value at that edge. `STEP_CYCLES` cycles later `ctrl_rst_no` and `slot_pwr_en_o` go low and the block is idle.
- R9: `shutdown_i` in idle has no effect, and `phy_prog_done_i` has no effect outside the request step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start the power-up sequence (idle only) |
| shutdown_i | input | 1 | Return outputs to the reset-asserted state |
| phy_prog_done_i | input | 1 | PHY configuration engine reports completion |
| slot_rst_no | output | 1 | Slot reset line, active low |
| slot_pwr_en_o | output | 1 | Slot power enable |
| ctrl_rst_no | output | 1 | Controller internal reset, active low |
| aux_clk_en_o | output | 1 | Auxiliary clock gate enable |
| phy_hold_o | output | 1 | Holds PHY and link state machine in reset |
| pwrup_rst_no | output | 1 | Controller power-up reset, active low |
| phy_prog_req_o | output | 1 | Request to the PHY configuration engine |
| dev_type_o | output | DEV_TYPE_W | Device-type setting, 4 selects root complex |
| done_o | output | 1 | Sequence complete |

## Verification
Every output is registered and moves at the same edge that samples `start_i`, `shutdown_i` or `phy_prog_done_i`, so each response is due one edge after its stimulus. Each timed step then lasts exactly `PERST_CYCLES` or `STEP_CYCLES` edges. The bench drives inputs and samples outputs on the falling edge. It checks the full expected output vector on every cycle of every step, so a response that arrives one cycle early or late fails in that cycle. The random PHY latency and the random shutdown points move these edges around, and the bench works out where the controller reset must stand at each shutdown from the cycle count since start.

// File: rtl/pcie_pwrup_pkg.sv
package pcie_pwrup_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_PWR, ST_REL_CTRL, ST_REL_SLOT, ST_AUX_ON, ST_HOLD, ST_PWRUP,
    ST_PHY_REQ, ST_AUX_OFF, ST_HOLD_CLR, ST_AUX_ON2, ST_DONE, ST_DOWN
  } seq_state_e;

  typedef struct packed {
    logic slot_rst_n;
    logic pwr_en;
    logic ctrl_rst_n;
    logic aux_en;
    logic phy_hold;
    logic pwrup_rst_n;
    logic phy_req;
    logic rc_mode;
    logic done;
  } seq_out_t;

  function automatic seq_out_t decode_state(seq_state_e st);
    seq_out_t o;
    o = '0;
    case (st)
      ST_PWR:      o.pwr_en = 1'b1;
      ST_REL_CTRL: o = '{slot_rst_n:1'b0, pwr_en:1'b1, ctrl_rst_n:1'b1, default:1'b0};
      ST_REL_SLOT: o = '{slot_rst_n:1'b1, pwr_en:1'b1, ctrl_rst_n:1'b1, default:1'b0};
      ST_AUX_ON:   o = '{slot_rst_n:1'b1, pwr_en:1'b1, ctrl_rst_n:1'b1, aux_en:1'b1, default:1'b0};
      ST_HOLD:     o = '{slot_rst_n:1'b1, pwr_en:1'b1, ctrl_rst_n:1'b1, aux_en:1'b1,
                         phy_hold:1'b1, default:1'b0};
      ST_PWRUP:    o = '{slot_rst_n:1'b1, pwr_en:1'b1, ctrl_rst_n:1'b1, aux_en:1'b1,
                         phy_hold:1'b1, pwrup_rst_n:1'b1, default:1'b0};
      ST_PHY_REQ:  o = '{slot_rst_n:1'b1, pwr_en:1'b1, ctrl_rst_n:1'b1, aux_en:1'b1,
                         phy_hold:1'b1, pwrup_rst_n:1'b1, phy_req:1'b1, default:1'b0};
      ST_AUX_OFF:  o = '{slot_rst_n:1'b1, pwr_en:1'b1, ctrl_rst_n:1'b1, phy_hold:1'b1,
                         pwrup_rst_n:1'b1, default:1'b0};
      ST_HOLD_CLR: o = '{slot_rst_n:1'b1, pwr_en:1'b1, ctrl_rst_n:1'b1,
                         pwrup_rst_n:1'b1, default:1'b0};
      ST_AUX_ON2:  o = '{slot_rst_n:1'b1, pwr_en:1'b1, ctrl_rst_n:1'b1, aux_en:1'b1,
                         pwrup_rst_n:1'b1, default:1'b0};
      ST_DONE:     o = '{slot_rst_n:1'b1, pwr_en:1'b1, ctrl_rst_n:1'b1, aux_en:1'b1,
                         pwrup_rst_n:1'b1, rc_mode:1'b1, done:1'b1, default:1'b0};
      default:     o = '0;
    endcase
    return o;
  endfunction

endpackage

// File: rtl/pcie_pwrup_timer.sv
module pcie_pwrup_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             expired_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);

  // R2: once expired and not reloaded the count never wraps
  a_r2_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expired_o && !load_i) |=> expired_o);

endmodule

// File: rtl/pcie_pwrup_fsm.sv
module pcie_pwrup_fsm
  import pcie_pwrup_pkg::*;
#(
  parameter int CNT_W        = 8,
  parameter int PERST_CYCLES = 100,
  parameter int STEP_CYCLES  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             shutdown_i,
  input  logic             phy_prog_done_i,
  input  logic             expired_i,
  output logic             load_o,
  output logic [CNT_W-1:0] load_val_o,
  output seq_state_e       state_d_o
);

  localparam logic [CNT_W-1:0] PerstLd = CNT_W'(PERST_CYCLES - 1);
  localparam logic [CNT_W-1:0] StepLd  = CNT_W'(STEP_CYCLES - 1);

  seq_state_e state_q, state_d;

  always_comb begin
    state_d    = state_q;
    load_o     = 1'b0;
    load_val_o = StepLd;
    if (shutdown_i && state_q != ST_IDLE && state_q != ST_DOWN) begin
      state_d = ST_DOWN;
      load_o  = 1'b1;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) begin
          state_d    = ST_PWR;
          load_o     = 1'b1;
          load_val_o = PerstLd;
        end
        ST_PHY_REQ: if (phy_prog_done_i) begin
          state_d = ST_AUX_OFF;
          load_o  = 1'b1;
        end
        ST_DONE: ;
        ST_DOWN: if (expired_i) state_d = ST_IDLE;
        default: if (expired_i) begin
          state_d = seq_state_e'(state_q + 4'd1);
          load_o  = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_d_o = state_d;

  // R5: the request step waits for the engine
  a_r5_wait_engine: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PHY_REQ && !phy_prog_done_i && !shutdown_i) |=> state_q == ST_PHY_REQ);
  // R9: idle ignores everything but start
  a_r9_idle_stays: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && !start_i) |=> state_q == ST_IDLE);
  // R7: done persists without shutdown
  a_r7_done_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DONE && !shutdown_i) |=> state_q == ST_DONE);

endmodule

// File: rtl/pcie_pwrup_outreg.sv
module pcie_pwrup_outreg
  import pcie_pwrup_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  seq_state_e state_d_i,
  output seq_out_t   out_o
);

  seq_out_t out_q, out_d;

  always_comb begin
    out_d = decode_state(state_d_i);
    // slot drops first; controller reset and power follow one step later
    if (state_d_i == ST_DOWN) begin
      out_d.pwr_en     = out_q.pwr_en;
      out_d.ctrl_rst_n = out_q.ctrl_rst_n;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_q <= '0;
    else         out_q <= out_d;
  end

  assign out_o = out_q;

  // R3: slot leaves reset only after the controller
  a_r3_ctrl_before_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_q.slot_rst_n) |-> $past(out_q.ctrl_rst_n));
  // R8: controller enters reset only after the slot
  a_r8_slot_before_ctrl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(out_q.ctrl_rst_n) |-> !$past(out_q.slot_rst_n));
  // R2: power is on before the controller is released
  a_r2_pwr_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_q.ctrl_rst_n) |-> $past(out_q.pwr_en));
  // R5: requests only go out with PHY held
  a_r5_req_in_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_q.phy_req |-> (out_q.phy_hold && out_q.pwrup_rst_n && out_q.aux_en));
  // R6: hold is released with the aux clock gated
  a_r6_hold_clear_clk_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(out_q.phy_hold) |-> !out_q.aux_en);
  // R7: done implies root-complex mode
  a_r7_done_rc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_q.done |-> (out_q.rc_mode && out_q.slot_rst_n));

endmodule

// File: rtl/pcie_pwrup_seq.sv
module pcie_pwrup_seq
  import pcie_pwrup_pkg::*;
#(
  parameter int PERST_CYCLES = 10_000_000,
  parameter int STEP_CYCLES  = 16,
  parameter int DEV_TYPE_W   = 4,
  parameter int DEV_TYPE_RC  = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic                  shutdown_i,
  input  logic                  phy_prog_done_i,
  output logic                  slot_rst_no,
  output logic                  slot_pwr_en_o,
  output logic                  ctrl_rst_no,
  output logic                  aux_clk_en_o,
  output logic                  phy_hold_o,
  output logic                  pwrup_rst_no,
  output logic                  phy_prog_req_o,
  output logic [DEV_TYPE_W-1:0] dev_type_o,
  output logic                  done_o
);

  localparam int MaxCnt = (PERST_CYCLES > STEP_CYCLES) ? PERST_CYCLES : STEP_CYCLES;
  localparam int CntW   = $clog2(MaxCnt + 1);

  logic            load, expired;
  logic [CntW-1:0] load_val;
  seq_state_e      state_d;
  seq_out_t        outs;

  pcie_pwrup_timer #(.CNT_W(CntW)) u_timer (
    .clk_i, .rst_ni, .load_i(load), .load_val_i(load_val), .expired_o(expired)
  );

  pcie_pwrup_fsm #(
    .CNT_W(CntW), .PERST_CYCLES(PERST_CYCLES), .STEP_CYCLES(STEP_CYCLES)
  ) u_fsm (
    .clk_i, .rst_ni, .start_i, .shutdown_i, .phy_prog_done_i,
    .expired_i(expired), .load_o(load), .load_val_o(load_val), .state_d_o(state_d)
  );

  pcie_pwrup_outreg u_outreg (
    .clk_i, .rst_ni, .state_d_i(state_d), .out_o(outs)
  );

  assign slot_rst_no    = outs.slot_rst_n;
  assign slot_pwr_en_o  = outs.pwr_en;
  assign ctrl_rst_no    = outs.ctrl_rst_n;
  assign aux_clk_en_o   = outs.aux_en;
  assign phy_hold_o     = outs.phy_hold;
  assign pwrup_rst_no   = outs.pwrup_rst_n;
  assign phy_prog_req_o = outs.phy_req;
  assign done_o         = outs.done;
  assign dev_type_o     = outs.rc_mode ? DEV_TYPE_W'(DEV_TYPE_RC) : '0;

endmodule

// File: tb/pcie_pwrup_seq_bench.sv
module pcie_pwrup_seq_bench;

  localparam int P = 40;
  localparam int S = 3;

  localparam int PH_IDLE = 0, PH_PWR = 1, PH_REL_CTRL = 2, PH_REL_SLOT = 3, PH_AUX_ON = 4,
                 PH_HOLD = 5, PH_PWRUP = 6, PH_PHY_REQ = 7, PH_AUX_OFF = 8,
                 PH_HOLD_CLR = 9, PH_AUX_ON2 = 10, PH_DONE = 11, PH_DOWN = 12;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic start_i = 1'b0, shutdown_i = 1'b0, phy_prog_done_i = 1'b0;
  logic slot_rst_no, slot_pwr_en_o, ctrl_rst_no, aux_clk_en_o, phy_hold_o;
  logic pwrup_rst_no, phy_prog_req_o, done_o;
  logic [3:0] dev_type_o;

  int n_checks = 0, n_errs = 0;
  bit finished = 0;

  always #5 clk_i = ~clk_i;

  pcie_pwrup_seq #(.PERST_CYCLES(P), .STEP_CYCLES(S)) u_pcie_pwrup_seq (.*);

  // {slot, pwr, ctrl, aux, hold, pwrup, req, done, dev_type[3:0]}
  function automatic logic [11:0] exp_vec(int ph, bit c);
    logic [7:0] b;
    case (ph)
      PH_PWR:      b = 8'b0100_0000;
      PH_REL_CTRL: b = 8'b0110_0000;
      PH_REL_SLOT: b = 8'b1110_0000;
      PH_AUX_ON:   b = 8'b1111_0000;
      PH_HOLD:     b = 8'b1111_1000;
      PH_PWRUP:    b = 8'b1111_1100;
      PH_PHY_REQ:  b = 8'b1111_1110;
      PH_AUX_OFF:  b = 8'b1110_1100;
      PH_HOLD_CLR: b = 8'b1110_0100;
      PH_AUX_ON2:  b = 8'b1111_0100;
      PH_DONE:     b = 8'b1111_0101;
      PH_DOWN:     b = {2'b01, c, 5'b0};
      default:     b = 8'b0;
    endcase
    return {b, (ph == PH_DONE) ? 4'd4 : 4'd0};
  endfunction

  task automatic chk(int ph, bit c, string req);
    logic [11:0] a, e;
    a = {slot_rst_no, slot_pwr_en_o, ctrl_rst_no, aux_clk_en_o, phy_hold_o,
         pwrup_rst_no, phy_prog_req_o, done_o, dev_type_o};
    e = exp_vec(ph, c);
    n_checks++;
    if (a !== e) begin
      n_errs++;
      $display("FAIL %s phase=%0d actual=%b expected=%b", req, ph, a, e);
    end
  endtask

  task automatic span(int n, int ph, bit c, string req);
    for (int i = 0; i < n; i++) begin
      chk(ph, c, req);
      @(negedge clk_i);
    end
  endtask

  task automatic pulse_start();
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  task automatic do_shutdown(bit c);
    shutdown_i = 1'b1;
    @(negedge clk_i);
    shutdown_i = 1'b0;
    span(S, PH_DOWN, c, "R8");
    span(2, PH_IDLE, 1'b0, "R8");
  endtask

  task automatic run_full(int lat);
    pulse_start();
    span(P, PH_PWR, 1'b0, "R2");
    span(S, PH_REL_CTRL, 1'b0, "R3");
    span(S, PH_REL_SLOT, 1'b0, "R3");
    span(S, PH_AUX_ON, 1'b0, "R4");
    // r9_: engine done outside the request step must not advance
    phy_prog_done_i = 1'b1;
    span(S, PH_HOLD, 1'b0, "R9");
    phy_prog_done_i = 1'b0;
    span(S, PH_PWRUP, 1'b0, "R4");
    span(lat, PH_PHY_REQ, 1'b0, "R5");
    phy_prog_done_i = 1'b1;
    chk(PH_PHY_REQ, 1'b0, "R5");
    @(negedge clk_i);
    phy_prog_done_i = 1'b0;
    span(S, PH_AUX_OFF, 1'b0, "R6");
    span(S, PH_HOLD_CLR, 1'b0, "R6");
    span(S, PH_AUX_ON2, 1'b0, "R6");
    start_i = 1'b1;
    chk(PH_DONE, 1'b0, "R7");
    @(negedge clk_i);
    start_i = 1'b0;
    span(4, PH_DONE, 1'b0, "R7");
    do_shutdown(1'b1);
  endtask

  task automatic run_abort(int k);
    pulse_start();
    repeat (k) @(negedge clk_i);
    do_shutdown(k >= P);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk_i);
    chk(PH_IDLE, 1'b0, "R1");
    @(negedge clk_i);
    rst_ni = 1'b1;
    span(3, PH_IDLE, 1'b0, "R1");
    // R9: shutdown in idle
    shutdown_i = 1'b1;
    @(negedge clk_i);
    shutdown_i = 1'b0;
    span(3, PH_IDLE, 1'b0, "R9");
    run_full(0);
    for (int r = 0; r < 6; r++) run_full(int'($urandom_range(20, 1)));
    run_abort(0);
    run_abort(P - 1);
    run_abort(P);
    for (int r = 0; r < 8; r++) run_abort(int'($urandom_range(P + 6 * S + 5, 0)));
    run_full(2);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      n_errs++;
      n_checks++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
    end
  end

endmodule